// File: doc/BRIEF.md
# ASCII Hex Record Memory Loader

This block takes a stream of ASCII characters, one per cycle on a valid/data pair, and loads memory from hexadecimal object records in that stream. A typical source is a serial receiver feeding a program image during boot. Each record opens with a colon. Next come a byte count, a 16-bit load address, a record type, the payload bytes and a checksum byte. Every byte is written as two hex digits.

Payload bytes go out on a memory write port as soon as each one is complete. The block does not hold back a whole record first. The checksum is checked at the end of the record, and a failure raises a sticky flag. Malformed input raises a separate sticky flag and drops the rest of the record. When an end-of-file record with a good checksum arrives, the block raises a done flag and ignores all further input until reset. Only two record types are accepted: data (00) and end-of-file (01).

Top module: `hexld_loader`

## Requirements
- R1: While reset is applied, and right after it is released, `wr_en`, `sum_err`, `fmt_err` and `done` are all low.
- R2: A record starts only with a colon (0x3A) accepted while `in_valid` is high. Outside a record, every other character is ignored, and so is any cycle with `in_valid` low.
- R3: After the colon, the fields are read in this order: 2 digits of length, 4 digits of address (most significant first), 2 digits of type, the payload, and 2 digits of checksum. Payload byte i is written to address (record address + i) modulo 2^16.
- R4: The digits 0-9, A-F and a-f are all accepted as hex, with the same values.
- R5: Each payload write is a single-cycle `wr_en` pulse with `wr_addr` and `wr_data`. It appears in the cycle after the cycle in which the second digit of that byte was accepted.
- R6: The 8-bit sum of the length, both address bytes, the type, the payload and the checksum must be zero. If it is not, `sum_err` goes high and stays high until reset. Payload writes already issued are not withdrawn.
- R7: A character inside a record that is neither a hex digit nor a colon sets `fmt_err`, which stays high until reset. The rest of the record is then ignored until the next colon.
- R8: A type other than 00 or 01, or a type 01 with a non-zero length, sets `fmt_err` and discards the rest of the record. No writes come from such a record.
- R9: A colon that arrives inside an unfinished record sets `fmt_err` and starts a new record, which is then handled normally.
- R10: An end-of-file record (type 01, length 0) with a correct checksum sets `done`, which stays high until reset. If its checksum is wrong, it sets `sum_err` and does not set `done`.
- R11: Once `done` is high, all input is ignored: there are no further writes and `sum_err` and `fmt_err` do not change.
- R12: A data record with length 0 and a correct checksum produces no writes and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | High when `in_char` holds a character to accept this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | ADDR_W (16) | Memory write address |
| wr_data | output | 8 | Memory write data |
| sum_err | output | 1 | Sticky flag: a record checksum was wrong |
| fmt_err | output | 1 | Sticky flag: a bad character, a bad type or a broken record was seen |
| done | output | 1 | Sticky flag: a valid end-of-file record was received |

## Verification
A wrong field or byte-position state shows up at the first write of the affected record. That write carries a shifted address or data byte, or appears one character early or late, so it is caught within two characters. A wrong state for the running sum or the record type is only visible at the checksum digit, which ends the record: `sum_err` or `done` is then wrong in the next cycle. Directed records that wrap the address, use lower-case digits, carry a broken checksum, or are cut short by a bad character or a colon each expose one of these states at its earliest visible point.

// File: rtl/hexld_pkg.sv
package hexld_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LEN,
    ST_ADDR,
    ST_TYPE,
    ST_DATA,
    ST_SUM,
    ST_DONE
  } ld_state_e;

  localparam logic [7:0] CH_COLON  = 8'h3A;
  localparam logic [7:0] TYPE_DATA = 8'h00;
  localparam logic [7:0] TYPE_EOF  = 8'h01;
endpackage

// File: rtl/hexld_nibble_dec.sv
module hexld_nibble_dec (
  input  logic [7:0] ch,
  output logic [3:0] nib,
  output logic       is_hex,
  output logic       is_colon
);
  import hexld_pkg::*;

  always_comb begin
    nib    = 4'h0;
    is_hex = 1'b1;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      nib = ch[3:0];
    end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
      nib = ch[3:0] + 4'd9;
    end else begin
      is_hex = 1'b0;
    end
  end

  assign is_colon = (ch == CH_COLON);
endmodule

// File: rtl/hexld_byte_asm.sv
module hexld_byte_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       nib_en,
  input  logic [3:0] nib,
  output logic       byte_vld,
  output logic [7:0] byte_o
);
  logic       phase_q, phase_d;
  logic [3:0] hi_q, hi_d;

  always_comb begin
    phase_d = phase_q;
    hi_d    = hi_q;
    if (clr) begin
      phase_d = 1'b0;
    end else if (nib_en) begin
      phase_d = ~phase_q;
      if (!phase_q) hi_d = nib;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hi_q    <= 4'h0;
    end else begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
    end
  end

  assign byte_vld = nib_en && phase_q && !clr;
  assign byte_o   = {hi_q, nib};
endmodule

// File: rtl/hexld_sum_acc.sv
module hexld_sum_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       add_en,
  input  logic [7:0] add_byte,
  output logic [7:0] sum_o
);
  logic [7:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr)         sum_d = 8'h00;
    else if (add_en) sum_d = sum_q + add_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= 8'h00;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/hexld_loader.sv
module hexld_loader #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sum_err,
  output logic              fmt_err,
  output logic              done
);
  import hexld_pkg::*;

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [7:0] ADDR_LAST = 8'(ADDR_BYTES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  ld_state_e         state_q, state_d;
  logic [7:0]        len_q, len_d;
  logic [7:0]        idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              eof_q, eof_d;
  logic              wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [7:0]        wr_data_q, wr_data_d;
  logic              sum_err_q, sum_err_d;
  logic              fmt_err_q, fmt_err_d;
  logic              done_q, done_d;

  logic [3:0] nib;
  logic       is_hex, is_colon;
  logic       accept, in_rec, colon_in, hex_in, bad_in;
  logic       byte_vld;
  logic [7:0] byte_v;
  logic       sum_clr, sum_add;
  logic [7:0] sum_q, sum_tot;

  hexld_nibble_dec u_dec (
    .ch       (in_char),
    .nib      (nib),
    .is_hex   (is_hex),
    .is_colon (is_colon)
  );

  assign accept   = in_valid && (state_q != ST_DONE);
  assign in_rec   = (state_q != ST_HUNT) && (state_q != ST_DONE);
  assign colon_in = accept && is_colon;
  assign hex_in   = accept && in_rec && is_hex;
  assign bad_in   = accept && in_rec && !is_hex && !is_colon;

  hexld_byte_asm u_asm (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (colon_in || bad_in),
    .nib_en   (hex_in),
    .nib      (nib),
    .byte_vld (byte_vld),
    .byte_o   (byte_v)
  );

  hexld_sum_acc u_sum (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (sum_clr),
    .add_en   (sum_add),
    .add_byte (byte_v),
    .sum_o    (sum_q)
  );

  assign sum_tot = sum_q + byte_v;

  always_comb begin
    state_d   = state_q;
    len_d     = len_q;
    idx_d     = idx_q;
    addr_d    = addr_q;
    eof_d     = eof_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    sum_err_d = sum_err_q;
    fmt_err_d = fmt_err_q;
    done_d    = done_q;
    sum_clr   = 1'b0;
    sum_add   = 1'b0;
    if (colon_in) begin
      if (in_rec) fmt_err_d = 1'b1;
      state_d = ST_LEN;
      idx_d   = 8'h00;
      sum_clr = 1'b1;
    end else if (bad_in) begin
      fmt_err_d = 1'b1;
      state_d   = ST_HUNT;
    end else if (byte_vld) begin
      sum_add = 1'b1;
      case (state_q)
        ST_LEN: begin
          len_d   = byte_v;
          idx_d   = 8'h00;
          state_d = ST_ADDR;
        end
        ST_ADDR: begin
          addr_d = {addr_q[ADDR_W-9:0], byte_v};
          if (idx_q == ADDR_LAST) begin
            idx_d   = 8'h00;
            state_d = ST_TYPE;
          end else begin
            idx_d = idx_q + 8'd1;
          end
        end
        ST_TYPE: begin
          if (byte_v == TYPE_DATA) begin
            eof_d   = 1'b0;
            state_d = (len_q == 8'h00) ? ST_SUM : ST_DATA;
          end else if (byte_v == TYPE_EOF && len_q == 8'h00) begin
            eof_d   = 1'b1;
            state_d = ST_SUM;
          end else begin
            fmt_err_d = 1'b1;
            state_d   = ST_HUNT;
          end
        end
        ST_DATA: begin
          wr_en_d   = 1'b1;
          wr_addr_d = addr_q + ADDR_W'(idx_q);
          wr_data_d = byte_v;
          idx_d     = idx_q + 8'd1;
          if (idx_q == len_q - 8'd1) state_d = ST_SUM;
        end
        ST_SUM: begin
          if (sum_tot != 8'h00) begin
            sum_err_d = 1'b1;
            state_d   = ST_HUNT;
          end else if (eof_q) begin
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_HUNT;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_HUNT;
      len_q     <= 8'h00;
      idx_q     <= 8'h00;
      addr_q    <= '0;
      eof_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= 8'h00;
      sum_err_q <= 1'b0;
      fmt_err_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      len_q     <= len_d;
      idx_q     <= idx_d;
      addr_q    <= addr_d;
      eof_q     <= eof_d;
      wr_en_q   <= wr_en_d;
      sum_err_q <= sum_err_d;
      fmt_err_q <= fmt_err_d;
      done_q    <= done_d;
      if (wr_en_d) begin
        wr_addr_q <= wr_addr_d;
        wr_data_q <= wr_data_d;
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign sum_err = sum_err_q;
  assign fmt_err = fmt_err_q;
  assign done    = done_q;

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_en |=> !wr_en);
  // R3
  wr_from_data_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_en |-> $past(state_q == ST_DATA));
  // R6
  sum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    sum_err |=> sum_err);
  // R7
  fmt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    fmt_err |=> fmt_err);
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> done);
  // R11
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> (!wr_en && $stable(sum_err) && $stable(fmt_err)));
endmodule

// File: tb/test_hexld_loader.sv
module test_hexld_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_char;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        sum_err, fmt_err, done;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  logic [15:0] wlog_a [0:31];
  logic [7:0]  wlog_d [0:31];
  int          wcnt = 0;
  logic [7:0]  pay [0:15];

  always #2 clk = ~clk;

  hexld_loader #(.ADDR_W(16)) i_hexld_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sum_err(sum_err), .fmt_err(fmt_err), .done(done)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (wcnt < 32) begin
        wlog_a[wcnt] = wr_addr;
        wlog_d[wcnt] = wr_data;
      end
      wcnt = wcnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] n, input bit lc);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lc ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
  endfunction

  task automatic do_reset();
    in_valid = 1'b0;
    in_char  = 8'h00;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    wcnt  = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lc);
    send_char(hexch(b[7:4], lc));
    send_char(hexch(b[3:0], lc));
  endtask

  task automatic send_rec(input int len, input logic [15:0] addr, input logic [7:0] typ,
                          input bit lc, input logic [7:0] bias);
    logic [7:0] s;
    s = 8'(len) + addr[15:8] + addr[7:0] + typ;
    send_char(8'h3A);
    send_byte(8'(len), lc);
    send_byte(addr[15:8], lc);
    send_byte(addr[7:0], lc);
    send_byte(typ, lc);
    for (int i = 0; i < len; i++) begin
      send_byte(pay[i], lc);
      s = s + pay[i];
    end
    send_byte(8'h00 - s + bias, lc);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_char = 8'h00;
    repeat (2) @(negedge clk);
    chk("R1", "wr_en in reset", wr_en, 0);
    chk("R1", "done in reset", done, 0);
    do_reset();
    chk("R1", "flags after reset", {wr_en, sum_err, fmt_err, done}, 0);
  endtask

  task automatic t_basic();
    do_reset();
    send_str(" x\r\n");
    send_char(8'h3A);
    send_byte(8'h03, 0); send_byte(8'h12, 0); send_byte(8'h34, 0); send_byte(8'h00, 0);
    send_char("1");
    chk("R5", "no strobe after first digit", wr_en, 0);
    send_char("1");
    chk("R5", "strobe after second digit", wr_en, 1);
    chk("R3", "first addr", wr_addr, 16'h1234);
    chk("R3", "first data", wr_data, 8'h11);
    @(negedge clk);
    chk("R5", "strobe lasts one cycle", wr_en, 0);
    send_byte(8'h22, 0); send_byte(8'h33, 0);
    send_byte(8'h00 - (8'h03 + 8'h12 + 8'h34 + 8'h11 + 8'h22 + 8'h33), 0);
    repeat (2) @(negedge clk);
    chk("R3", "write count", wcnt, 3);
    chk("R3", "addr 2", wlog_a[1], 16'h1235);
    chk("R3", "data 2", wlog_d[1], 8'h22);
    chk("R3", "addr 3", wlog_a[2], 16'h1236);
    chk("R3", "data 3", wlog_d[2], 8'h33);
    chk("R6", "no errors on clean record", {sum_err, fmt_err}, 0);
  endtask

  task automatic t_case_junk();
    do_reset();
    in_char = 8'h3A; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    send_str("\r\nZZ?");
    chk("R2", "stray chars ignored", fmt_err, 0);
    pay[0] = 8'hDE; pay[1] = 8'hAD;
    send_rec(2, 16'hABCD, 8'h00, 1, 8'h00);
    chk("R4", "lower-case writes", wcnt, 2);
    chk("R4", "addr 1", wlog_a[0], 16'hABCD);
    chk("R4", "data 1", wlog_d[0], 8'hDE);
    chk("R4", "data 2", wlog_d[1], 8'hAD);
    chk("R2", "no errors", {sum_err, fmt_err}, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    pay[0] = 8'h5A; pay[1] = 8'hA5;
    send_rec(2, 16'hFFFF, 8'h00, 0, 8'h00);
    chk("R3", "wrap count", wcnt, 2);
    chk("R3", "wrap addr 1", wlog_a[0], 16'hFFFF);
    chk("R3", "wrap addr 2", wlog_a[1], 16'h0000);
    chk("R3", "wrap data 2", wlog_d[1], 8'hA5);
  endtask

  task automatic t_zero();
    do_reset();
    send_rec(0, 16'h0100, 8'h00, 0, 8'h00);
    chk("R12", "no writes", wcnt, 0);
    chk("R12", "no flags", {sum_err, fmt_err, done}, 0);
  endtask

  task automatic t_badsum();
    do_reset();
    pay[0] = 8'h77;
    send_rec(1, 16'h0040, 8'h00, 0, 8'h01);
    chk("R6", "write not withdrawn", wcnt, 1);
    chk("R6", "sum_err set", sum_err, 1);
    chk("R6", "fmt_err clear", fmt_err, 0);
    pay[0] = 8'h66;
    send_rec(1, 16'h0050, 8'h00, 0, 8'h00);
    chk("R6", "sum_err sticky", sum_err, 1);
    chk("R6", "next record written", wlog_a[1], 16'h0050);
  endtask

  task automatic t_nonhex();
    do_reset();
    send_str(":03001000AAgBBCC00");
    repeat (2) @(negedge clk);
    chk("R7", "only first byte written", wcnt, 1);
    chk("R7", "fmt_err set", fmt_err, 1);
    chk("R7", "no sum_err", sum_err, 0);
  endtask

  task automatic t_badtype();
    do_reset();
    pay[0] = 8'h99;
    send_rec(1, 16'h0000, 8'h02, 0, 8'h00);
    chk("R8", "type 02 no write", wcnt, 0);
    chk("R8", "type 02 fmt_err", fmt_err, 1);
    do_reset();
    send_rec(1, 16'h0000, 8'h01, 0, 8'h00);
    chk("R8", "eof with length fmt_err", fmt_err, 1);
    chk("R8", "eof with length not done", done, 0);
  endtask

  task automatic t_colon();
    do_reset();
    send_str(":0200200011");
    pay[0] = 8'h44;
    send_rec(1, 16'h0030, 8'h00, 0, 8'h00);
    chk("R9", "fmt_err set", fmt_err, 1);
    chk("R9", "writes", wcnt, 2);
    chk("R9", "new record addr", wlog_a[1], 16'h0030);
    chk("R9", "new record data", wlog_d[1], 8'h44);
    chk("R9", "new record checksum ok", sum_err, 0);
  endtask

  task automatic t_eof();
    do_reset();
    send_str(":00000001FF\r\n");
    chk("R10", "done set", done, 1);
    chk("R10", "no errors", {sum_err, fmt_err}, 0);
    pay[0] = 8'h12;
    send_rec(1, 16'h0000, 8'h00, 0, 8'h00);
    send_str(":zz");
    send_rec(1, 16'h0000, 8'h00, 0, 8'h05);
    chk("R11", "no writes after done", wcnt, 0);
    chk("R11", "flags unchanged", {sum_err, fmt_err}, 0);
    chk("R10", "done held", done, 1);
    do_reset();
    send_str(":00000001FE");
    repeat (2) @(negedge clk);
    chk("R10", "bad eof not done", done, 0);
    chk("R10", "bad eof sum_err", sum_err, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_case_junk();
    t_wrap();
    t_zero();
    t_badsum();
    t_nonhex();
    t_badtype();
    t_colon();
    t_eof();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule